// File: doc/BRIEF.md
# Dual-Source Processor Clock Generator

This block derives the processor clock from one of two free-running oscillators and changes between them while the system runs. The base oscillator (nominally 14.318 MHz) divided by three gives the normal-speed clock of about 4.77 MHz, with a period near 210 ns. The fast oscillator (nominally 30 MHz) divided by three gives the turbo-speed clock of 10 MHz. A third output, the base oscillator divided by four (about 3.58 MHz), serves as the colour-burst reference. It runs whatever mode is selected.

A turbo request input chooses the source and may change at any time. The block treats it as asynchronous. The changeover never produces a short pulse. The running divider finishes its current period and parks low. The new divider starts only after each domain has seen, through synchronisers, that the other one has stopped. A status output reports which source drives the processor clock. It switches only on the first pulse that the new source delivers. Reset returns the block to normal mode and restarts both dividers from a fixed phase.

Top module: `cpu_clk_gen`

## Requirements
- R1: While rst_ni is low, cpu_clk_o, burst_clk_o and turbo_o are all 0.
- R2: With turbo_i held low since reset release, cpu_clk_o is 1 after rising base edge k (counted from 1 after release) exactly when (k-1) mod 3 = 0, and 0 otherwise, while turbo_o stays 0.
- R3: After rising base edge k since reset release, burst_clk_o is 1 exactly when k mod 4 is 2 or 3, regardless of turbo_i or of any changeover in progress.
- R4: While turbo_o is 1, consecutive rising edges of cpu_clk_o are three fast periods apart.
- R5: After turbo_i changes and is then held, turbo_o takes the same value within 1 us.
- R6: Every high phase of cpu_clk_o lasts exactly one period of either oscillator, and every low phase lasts at least two fast periods, including across a changeover.
- R7: turbo_o changes only at the same instant as a rising edge of cpu_clk_o, namely the first pulse from the newly selected source.
- R8: While turbo_o is 0 and no changeover is under way, consecutive rising edges of cpu_clk_o are three base periods apart.
- R9: A reset that arrives during turbo operation, released with turbo_i low, restarts the normal-mode pulse sequence of R2 from edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_base_i | input | 1 | Base oscillator, about 14.318 MHz |
| osc_fast_i | input | 1 | Fast oscillator, 30 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| turbo_i | input | 1 | Asynchronous turbo request; 1 selects the fast source |
| cpu_clk_o | output | 1 | Processor clock, one source period high in three |
| burst_clk_o | output | 1 | Colour-burst reference, base divided by four |
| turbo_o | output | 1 | 1 while the fast source drives cpu_clk_o |

## Verification
The bench targets the changeover. It asserts and drops the turbo request at several offsets against both oscillators and measures every high and low phase of the processor clock. A design that stopped the old divider in mid-period, or started the new one before the old one was parked, would show a runt high or low phase. A status flag taken from the request, or from either divider's enable alone, would change during the dead gap, when no pulse from the new source is present. The bench checks the burst output against an edge-count model throughout every switch, so a design that reset or stalled it on a mode change fails. A reset issued during turbo operation confirms that the normal sequence restarts from its first pulse.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
  localparam int unsigned CPU_DIV_DEF   = 3;
  localparam int unsigned BURST_DIV_DEF = 4;
  localparam int unsigned SYNC_DEF      = 2;
  localparam int unsigned NUM_SRC       = 2;
  localparam int unsigned SRC_BASE      = 0;
  localparam int unsigned SRC_FAST      = 1;
endpackage

// File: rtl/cgen_sync.sv
module cgen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cgen_gated_div.sv
module cgen_gated_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  output logic active_o,
  output logic q_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          pulse_q;

  // stop only at the end of a full period, so the output parks low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      pulse_q  <= 1'b0;
    end else if (!active_q) begin
      if (want_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        pulse_q  <= 1'b1;
      end
    end else if (cnt_q == LAST) begin
      if (want_i) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        active_q <= 1'b0;
        pulse_q  <= 1'b0;
      end
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign q_o      = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) pulse_q |=> !pulse_q); // R6
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(active_q) |-> pulse_q); // R7
  AST_STOP_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(active_q) |-> (!pulse_q && !$past(pulse_q))); // R6
  AST_NO_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni) (active_q && cnt_q != LAST) |=> active_q); // R6
endmodule

// File: rtl/cgen_burst_div.sv
module cgen_burst_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic burst_o
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          burst_q;

  assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      burst_q <= (cnt_nxt >= HALF);
    end
  end

  assign burst_o = burst_q;

  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (burst_q != $past(burst_q)) |=> $stable(burst_q)); // R3
  AST_BURST_RISE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(burst_q) |-> (cnt_q == HALF)); // R3
endmodule

// File: rtl/cpu_clk_gen.sv
module cpu_clk_gen #(
  parameter int unsigned CPU_DIV   = cgen_pkg::CPU_DIV_DEF,
  parameter int unsigned BURST_DIV = cgen_pkg::BURST_DIV_DEF,
  parameter int unsigned SYNC_N    = cgen_pkg::SYNC_DEF
) (
  input  logic osc_base_i,
  input  logic osc_fast_i,
  input  logic rst_ni,
  input  logic turbo_i,
  output logic cpu_clk_o,
  output logic burst_clk_o,
  output logic turbo_o
);
  localparam int unsigned NS = cgen_pkg::NUM_SRC;
  localparam int unsigned IB = cgen_pkg::SRC_BASE;
  localparam int unsigned IF = cgen_pkg::SRC_FAST;

  logic [NS-1:0] osc;
  logic [NS-1:0] sel_s;
  logic [NS-1:0] peer_s;
  logic [NS-1:0] want;
  logic [NS-1:0] active;
  logic [NS-1:0] pulse;
  logic          fast_held_q;

  assign osc[IB] = osc_base_i;
  assign osc[IF] = osc_fast_i;

  for (genvar g = 0; g < NS; g++) begin : g_src
    cgen_sync #(.STAGES(SYNC_N)) u_sel_sync (
      .clk_i (osc[g]),
      .rst_ni(rst_ni),
      .d_i   (turbo_i),
      .q_o   (sel_s[g])
    );
    cgen_sync #(.STAGES(SYNC_N)) u_peer_sync (
      .clk_i (osc[g]),
      .rst_ni(rst_ni),
      .d_i   (active[NS-1-g]),
      .q_o   (peer_s[g])
    );
    // start only once the other source is seen parked
    if (g == IF) begin : g_fast
      assign want[g] = sel_s[g] & ~peer_s[g];
    end else begin : g_base
      assign want[g] = ~sel_s[g] & ~peer_s[g];
    end
    cgen_gated_div #(.DIV(CPU_DIV)) u_div (
      .clk_i   (osc[g]),
      .rst_ni  (rst_ni),
      .want_i  (want[g]),
      .active_o(active[g]),
      .q_o     (pulse[g])
    );
  end

  // holds turbo status through the dead gap until base is running
  always_ff @(posedge osc_fast_i or negedge rst_ni) begin
    if (!rst_ni)         fast_held_q <= 1'b0;
    else if (active[IF]) fast_held_q <= 1'b1;
    else if (peer_s[IF]) fast_held_q <= 1'b0;
  end

  assign cpu_clk_o = |pulse;
  assign turbo_o   = (fast_held_q | active[IF]) & ~active[IB];

  cgen_burst_div #(.DIV(BURST_DIV)) u_burst (
    .clk_i  (osc_base_i),
    .rst_ni (rst_ni),
    .burst_o(burst_clk_o)
  );

  AST_ONE_SOURCE: assert property (@(posedge osc_fast_i) disable iff (!rst_ni) active[IF] |-> !active[IB]); // R6
  AST_STATUS_FAST: assert property (@(posedge osc_fast_i) disable iff (!rst_ni) active[IF] |-> turbo_o); // R7
  AST_STATUS_BASE: assert property (@(posedge osc_base_i) disable iff (!rst_ni) active[IB] |-> !turbo_o); // R7
endmodule

// File: tb/tb_cpu_clk_gen.sv
`timescale 1ns/1ps
module tb_cpu_clk_gen;
  logic clk = 1'b0;
  logic osc_base = 1'b0;
  logic osc_fast = 1'b0;
  logic rst_n = 1'b0;
  logic turbo = 1'b0;
  logic cpu_clk, burst_clk, turbo_st;

  localparam real T_BASE = 69.84;
  localparam real T_FAST = 33.334;

  always #5 clk = ~clk;
  always #34.92 osc_base = ~osc_base;
  always #16.667 osc_fast = ~osc_fast;

  cpu_clk_gen dut (
    .osc_base_i (osc_base),
    .osc_fast_i (osc_fast),
    .rst_ni     (rst_n),
    .turbo_i    (turbo),
    .cpu_clk_o  (cpu_clk),
    .burst_clk_o(burst_clk),
    .turbo_o    (turbo_st)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk_i(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $realtime, act, exp);
    end
  endtask

  task automatic chk_r(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0.3f expected=%0.3f", req, $realtime, act, exp);
    end
  endtask

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  // edge-count reference for base domain
  int k = 0;
  bit model_on = 0;
  always @(posedge osc_base or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  always @(negedge osc_base) begin
    if (rst_n) begin
      chk_i(burst_clk == (((k % 4) >= 2) ? 1'b1 : 1'b0), "R3 burst", int'(burst_clk), int'((k % 4) >= 2));
      if (model_on) begin
        chk_i(cpu_clk == ((k >= 1 && ((k - 1) % 3) == 0) ? 1'b1 : 1'b0), "R2/R9 normal pulse",
              int'(cpu_clk), int'(k >= 1 && ((k - 1) % 3) == 0));
        chk_i(turbo_st == 1'b0, "R2 status low", int'(turbo_st), 0);
      end
    end
  end

  // phase and period measurement on cpu clock
  realtime t_r = -1.0;
  realtime t_f = -1.0;
  realtime t_prev = -1.0;
  bit have_prev = 0;
  bit prev_src = 0;
  bit src_now = 0;

  always @(negedge rst_n) have_prev = 0;

  always @(posedge cpu_clk) begin
    if (t_f >= 0.0 && rst_n)
      chk_r(($realtime - t_f) >= 2.0 * T_FAST - 0.1, "R6 low phase", $realtime - t_f, 2.0 * T_FAST);
    t_prev = t_r;
    t_r = $realtime;
    #0.1;
    src_now = turbo_st;
    if (have_prev && rst_n && src_now == prev_src) begin
      if (src_now)
        chk_r(absr(t_r - t_prev - 3.0 * T_FAST) < 0.2, "R4 turbo period", t_r - t_prev, 3.0 * T_FAST);
      else
        chk_r(absr(t_r - t_prev - 3.0 * T_BASE) < 0.2, "R8 normal period", t_r - t_prev, 3.0 * T_BASE);
    end
    prev_src = src_now;
    have_prev = rst_n;
  end

  always @(negedge cpu_clk) begin
    t_f = $realtime;
    if (rst_n && t_r >= 0.0)
      chk_r(absr(t_f - t_r - T_FAST) < 0.1 || absr(t_f - t_r - T_BASE) < 0.1, "R6 high phase",
            t_f - t_r, T_FAST);
  end

  always @(posedge turbo_st) begin
    #0.1;
    chk_r(cpu_clk == 1'b1 && ($realtime - t_r) < 0.2, "R7 status rise on new pulse", $realtime - t_r, 0.1);
  end

  always @(negedge turbo_st) begin
    #0.1;
    if (rst_n)
      chk_r(cpu_clk == 1'b1 && ($realtime - t_r) < 0.2, "R7 status fall on new pulse", $realtime - t_r, 0.1);
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      summary();
    end
  end

  initial begin
    #1;
    chk_i({cpu_clk, burst_clk, turbo_st} == 3'b000, "R1 reset outputs", int'({cpu_clk, burst_clk, turbo_st}), 0);
    #100;
    chk_i({cpu_clk, burst_clk, turbo_st} == 3'b000, "R1 reset outputs held", int'({cpu_clk, burst_clk, turbo_st}), 0);
    #90;
    rst_n = 1'b1;
    model_on = 1;
    #3000;
    model_on = 0;
    turbo = 1'b1;
    #1000;
    chk_i(turbo_st == 1'b1, "R5 enter turbo", int'(turbo_st), 1);
    #3000;
    turbo = 1'b0;
    #1000;
    chk_i(turbo_st == 1'b0, "R5 leave turbo", int'(turbo_st), 0);
    #2000;
    for (int i = 0; i < 4; i++) begin
      #(137.0 + 41.3 * i);
      turbo = 1'b1;
      #1200;
      chk_i(turbo_st == 1'b1, "R5 enter turbo at offset", int'(turbo_st), 1);
      #(500.0 + 77.7 * i);
      turbo = 1'b0;
      #1200;
      chk_i(turbo_st == 1'b0, "R5 leave turbo at offset", int'(turbo_st), 0);
    end
    turbo = 1'b1;
    #1500;
    chk_i(turbo_st == 1'b1, "R5 turbo before reset", int'(turbo_st), 1);
    #23.1;
    rst_n = 1'b0;
    #1;
    chk_i({cpu_clk, burst_clk, turbo_st} == 3'b000, "R1 reset in turbo", int'({cpu_clk, burst_clk, turbo_st}), 0);
    turbo = 1'b0;
    #200;
    chk_i({cpu_clk, burst_clk, turbo_st} == 3'b000, "R1 reset in turbo held", int'({cpu_clk, burst_clk, turbo_st}), 0);
    @(negedge osc_base);
    #5;
    rst_n = 1'b1;
    model_on = 1;
    #3000;
    model_on = 0;
    summary();
  end
endmodule